// File: doc/BRIEF.md
# Selectable CRC5/CRC16 Engine

This is a serial cyclic-redundancy unit that takes one bit on each clock in which its strobe is high. A two-bit select picks one of four variants: two 5-bit codes that share one polynomial but have different presets, and two 16-bit codes. The same register is used in both directions. When a frame is sent, the running value is read out and appended. When a frame is received, the whole frame is fed through the unit, CRC field included, and the check flag shows whether the register landed on the residue expected for the selected variant.

An init pulse loads the preset of the variant that is currently selected. A select change on its own does not touch the register. Data enters MSB first. Byte-parallel operation and the placement of the CRC inside a command stream are handled elsewhere.

Top module: `crc_multi`

## Requirements
- R1: After reset, the internal register is zero, `crc_q` reads 0x0000 and, with select 00, `chk_ok` is 1.
- R2: A cycle with `init` high loads the preset of the current select into the register: 00 loads 0x09, 01 loads 0x12, and 10 or 11 loads 0xFFFF. For 00 and 01, bits 15:5 are cleared.
- R3: A cycle with both `init` and `bit_vld` low leaves the register and `crc_q` unchanged.
- R4: Select 00 and 01 use the polynomial x^5+x^3+1 on register bits 4:0 and are processed MSB first. After preset 0x09, the ASCII string "123456789" yields 0x00. `crc_q[15:5]` reads as zero in 5-bit mode.
- R5: Select 10 uses x^16+x^12+x^5+1. After preset 0xFFFF, "123456789" yields 0x29B1.
- R6: Select 11 uses x^16+x^15+x^2+1. After preset 0xFFFF, "123456789" yields 0xAEE7.
- R7: A select change without `init` leaves the stored 16 bits untouched. Switching from a 16-bit to a 5-bit select and back shows the same 16-bit value again.
- R8: `chk_ok` is 1 when the register holds the residue of the selected variant: bits 4:0 zero for 00 and 01, 0x1D0F for 10, and 0x0000 for 11. It is valid in the cycle after the last bit is consumed. The CRC is appended MSB first: as-is for 00, 01 and 11, and inverted for 10.
- R9: When `init` and `bit_vld` are high in the same cycle, the preset load wins and the bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Variant select (00, 01, 10, 11 as in R2) |
| init | input | 1 | Load the preset of the selected variant |
| bit_vld | input | 1 | Consume `bit_in` this cycle |
| bit_in | input | 1 | Serial data bit, MSB first |
| crc_q | output | 16 | Current CRC value, zero-extended in 5-bit mode |
| chk_ok | output | 1 | Register equals the residue of the selected variant |

## Verification
The hardest case to reach from the ports is the CRC16-CCITT check. It passes only on the non-zero residue 0x1D0F, and that residue appears only when the inverted CRC is appended to the frame. The bench therefore builds each check frame from a computed CRC, appends it in the form the variant needs, and then repeats the same frame with one data bit flipped to confirm the flag drops. The select-retention case is reached by loading a 16-bit preset, switching to a 5-bit select without `init`, and switching back.

// File: rtl/crc_multi.sv
module crc_multi #(
  parameter logic [4:0]  POLY5    = 5'h09,
  parameter logic [4:0]  PRE5_A   = 5'h09,
  parameter logic [4:0]  PRE5_B   = 5'h12,
  parameter logic [15:0] POLY16_A = 16'h1021,
  parameter logic [15:0] POLY16_B = 16'h8005,
  parameter logic [15:0] PRE16    = 16'hFFFF,
  parameter logic [15:0] RES16_A  = 16'h1D0F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  sel,
  input  logic        init,
  input  logic        bit_vld,
  input  logic        bit_in,
  output logic [15:0] crc_q,
  output logic        chk_ok
);
  localparam int W5 = $bits(POLY5);

  logic [15:0] r;
  logic        wide;
  logic [W5-1:0] nxt5;
  logic [15:0]   nxt16;
  logic [15:0]   preset;

  assign wide  = sel[1];
  assign nxt5  = {r[W5-2:0], 1'b0} ^ ((r[W5-1] ^ bit_in) ? POLY5 : '0);
  assign nxt16 = {r[14:0], 1'b0} ^ ((r[15] ^ bit_in) ? (sel[0] ? POLY16_B : POLY16_A) : 16'h0);

  always_comb begin
    case (sel)
      2'b00:   preset = {{(16-W5){1'b0}}, PRE5_A};
      2'b01:   preset = {{(16-W5){1'b0}}, PRE5_B};
      default: preset = PRE16;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       r <= '0;
    else if (init)    r <= preset;
    else if (bit_vld) r <= wide ? nxt16 : {r[15:W5], nxt5};
  end

  assign crc_q = wide ? r : {{(16-W5){1'b0}}, r[W5-1:0]};

  always_comb begin
    case (sel)
      2'b10:   chk_ok = (r == RES16_A);
      2'b11:   chk_ok = (r == 16'h0);
      default: chk_ok = (r[W5-1:0] == '0);
    endcase
  end

  assert_init_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> crc_q == (($past(sel) == 2'b00) ? 16'h0009 :
                       ($past(sel) == 2'b01) ? 16'h0012 : 16'hFFFF));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !bit_vld) |=> $stable(r));

  assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && bit_vld && !sel[1]) |=> r[15:5] == $past(r[15:5]));

  assert_alt16_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && bit_vld && sel == 2'b11) |=> (r[14:3] == $past(r[13:2])) && (r[1] == $past(r[0])));

  assert_ccitt16_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && bit_vld && sel == 2'b10) |=> (r[15:13] == $past(r[14:12])) && (r[11:6] == $past(r[10:5])));

  assert_zero_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel[1] |-> crc_q[15:5] == 11'h0);
endmodule

// File: tb/tb_crc_multi.sv
module tb_crc_multi;
  logic clk = 0, rst_n = 0, init = 0, bit_vld = 0, bit_in = 0;
  logic [1:0] sel = 0;
  logic [15:0] crc_q;
  logic chk_ok;
  int checks = 0, fails = 0;
  bit done = 0;

  crc_multi dut (.clk(clk), .rst_n(rst_n), .sel(sel), .init(init), .bit_vld(bit_vld),
                 .bit_in(bit_in), .crc_q(crc_q), .chk_ok(chk_ok));

  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]  s;
    logic [3:0]  nbytes;
    logic [71:0] msg;
    logic [15:0] expect_v;
    logic        known;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'b00, 4'd9, "123456789", 16'h0000, 1'b1},
    '{2'b10, 4'd9, "123456789", 16'h29B1, 1'b1},
    '{2'b11, 4'd9, "123456789", 16'hAEE7, 1'b1},
    '{2'b01, 4'd9, "123456789", 16'h0000, 1'b0},
    '{2'b10, 4'd4, 72'hDEADBEEF, 16'h0000, 1'b0},
    '{2'b00, 4'd1, 72'hA5, 16'h0000, 1'b0}
  };

  function automatic logic [15:0] model(input logic [1:0] s, input logic [71:0] m,
                                        input int nb, input int flip);
    logic [15:0] r;
    logic fb;
    r = (s == 2'b00) ? 16'h09 : (s == 2'b01) ? 16'h12 : 16'hFFFF;
    for (int i = 0; i < nb * 8; i++) begin
      logic b;
      b = m[nb*8-1-i] ^ (i == flip);
      if (s[1]) begin
        fb = r[15] ^ b;
        r = {r[14:0], 1'b0} ^ (fb ? (s[0] ? 16'h8005 : 16'h1021) : 16'h0);
      end else begin
        fb = r[4] ^ b;
        r = {11'h0, r[3:0], 1'b0} ^ (fb ? 16'h09 : 16'h0);
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic shift(input logic b);
    bit_vld = 1; bit_in = b;
    @(negedge clk);
    bit_vld = 0;
  endtask

  task automatic do_init(input logic [1:0] s);
    sel = s; init = 1;
    @(negedge clk);
    init = 0;
  endtask

  task automatic run_msg(input logic [71:0] m, input int nb, input int flip);
    for (int i = 0; i < nb * 8; i++) shift(m[nb*8-1-i] ^ (i == flip));
  endtask

  task automatic append(input logic [1:0] s, input logic [15:0] c);
    logic [15:0] a;
    a = (s == 2'b10) ? ~c : c;
    if (s[1]) for (int i = 15; i >= 0; i--) shift(a[i]);
    else      for (int i = 4; i >= 0; i--) shift(a[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset crc", crc_q, 16'h0);
    check("R1 reset chk", {15'h0, chk_ok}, 16'h1);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [15:0] e;
      int nb;
      nb = int'(VEC[v].nbytes);
      e = model(VEC[v].s, VEC[v].msg, nb, -1);
      if (VEC[v].known) e = VEC[v].expect_v;
      do_init(VEC[v].s);
      run_msg(VEC[v].msg, nb, -1);
      // R4 R5 R6 value after message
      check(VEC[v].s == 2'b10 ? "R5 value" : VEC[v].s == 2'b11 ? "R6 value" : "R4 value", crc_q, e);
      append(VEC[v].s, crc_q);
      check("R8 pass after append", {15'h0, chk_ok}, 16'h1);
      do_init(VEC[v].s);
      run_msg(VEC[v].msg, nb, 3);
      append(VEC[v].s, e);
      check("R8 fail on corrupted bit", {15'h0, chk_ok}, 16'h0);
    end

    do_init(2'b00); check("R2 preset 00", crc_q, 16'h0009);
    do_init(2'b01); check("R2 preset 01", crc_q, 16'h0012);
    do_init(2'b11); check("R2 preset 11", crc_q, 16'hFFFF);
    do_init(2'b10); check("R2 preset 10", crc_q, 16'hFFFF);
    check("R8 preset not residue", {15'h0, chk_ok}, 16'h0);

    shift(1'b1);
    begin
      logic [15:0] held;
      held = crc_q;
      repeat (4) @(negedge clk);
      check("R3 hold while idle", crc_q, held);
      sel = 2'b00; @(negedge clk);
      check("R7 5-bit view of 16-bit value", crc_q, {11'h0, held[4:0]});
      sel = 2'b10; @(negedge clk);
      check("R7 value retained after select change", crc_q, held);
    end

    do_init(2'b01);
    shift(1'b0);
    sel = 2'b10; @(negedge clk);
    check("R4 upper bits cleared by 5-bit init", crc_q[15:5], 16'h0);

    do_init(2'b11);
    sel = 2'b11; init = 1; bit_vld = 1; bit_in = 1;
    @(negedge clk);
    init = 0; bit_vld = 0;
    check("R9 init wins over bit", crc_q, 16'hFFFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule